// File: doc/BRIEF.md
# Two-Stage Lifting Wavelet Filter

This block computes a one-level forward 9/7-type wavelet transform of a line of samples. It takes a stream of signed samples one per clock, with a marker on the first and on the last sample of each line. It groups them into even/odd pairs and passes every pair through a ladder of four lifting steps: predict, update, predict, update. It then scales the two branches. For every input pair it returns one coarse (low-pass) and one detail (high-pass) coefficient, marked with the start and end of the line.

All lifting weights and gains are fixed signed fixed-point constants with 14 fraction bits. Internal values carry four guard bits above the sample width. Every product is rounded to nearest, half up, before it is cut back. Line edges use whole-sample mirror extension, so no padding has to be supplied. A line with an odd sample count raises a one-cycle error pulse, and its last sample is dropped.

Top module: `lwt_core`

## Requirements
- R1: After a clock edge with rst_n low, out_valid and err_odd are 0, and out_valid stays 0 until samples arrive.
- R2: Samples are numbered from 0 at the sample carrying in_sol, which is always an even sample x(2n). The sample that follows is x(2n+1), and the pair completes on it. Samples are DATA_W-bit two's complement and are sign-extended to W = DATA_W+4 bits.
- R3: The first predict step gives d1(n) = x(2n+1) + R(-25987 * (x(2n) + x(2n+2))), with R(p) = floor((p + 8192) / 16384).
- R4: The first update step gives s1(n) = x(2n) + R(-868 * (d1(n-1) + d1(n))).
- R5: The second predict and update steps act on the results of the first update: d2(n) = d1(n) + R(14466 * (s1(n) + s1(n+1))), then s2(n) = s1(n) + R(7266 * (d2(n-1) + d2(n))).
- R6: out_low = R(14252 * s2(n)) and out_high = R(18835 * d2(n)). Both are W-bit two's complement, and rounding is half up as defined in R3.
- R7: At the start of a line the missing left detail neighbours mirror: d1(-1) = d1(0) and d2(-1) = d2(0).
- R8: At the end of a line of N pairs the missing right neighbours mirror: x(2N) = x(2N-2) and s1(N) = s1(N-1).
- R9: Exactly one output pair is issued per input pair, in input order and never before both of its samples have entered. out_sol is 1 on the first pair of a line and out_eol is 1 on its last pair.
- R10: When in_eol arrives on an even sample, err_odd is 1 for one cycle after the clock edge that took that sample. The sample is dropped. The earlier pairs are output as a line of L-1 samples, and its last pair is issued once the next line's first pair has entered.
- R11: in_valid may drop between any two samples, and lines may follow each other with no idle cycle; the coefficients do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| in_sol | input | 1 | Marks the first sample of a line |
| in_eol | input | 1 | Marks the last sample of a line |
| out_valid | output | 1 | Coefficient pair strobe |
| out_low | output | DATA_W+4 | Scaled coarse coefficient |
| out_high | output | DATA_W+4 | Scaled detail coefficient |
| out_sol | output | 1 | First pair of a line |
| out_eol | output | 1 | Last pair of a line |
| err_odd | output | 1 | Odd-length line pulse |

## Verification
The assertions take for granted that at most one sample enters per clock, that every line opens with in_sol and closes with in_eol, and that a line holds at least two full pairs. Under those conditions the start and end markers on the output alternate strictly, and outputs never outnumber the pairs that have entered. The stimulus generator builds every line with exactly one opening and one closing marker and never drives two samples in one cycle. Line lengths run from 4 upwards, and the one odd line has 7 samples, so at least two full pairs are always present. The expected coefficients are computed in integer arithmetic from the formulas, including the mirror rules at both edges.

// File: rtl/lwt_pkg.sv
`timescale 1ns/1ps
// Shared constants of the lifting filter: coefficient format and the
// default Q2.14 weights of the four lifting steps and the output gains.
package lwt_pkg;
    localparam int LWT_COEF_W = 16;
    localparam int LWT_FRAC   = 14;
    localparam int LWT_STAGES = 2;
    localparam logic signed [15:0] LWT_PRED1 = -16'sd25987;
    localparam logic signed [15:0] LWT_UPD1  = -16'sd868;
    localparam logic signed [15:0] LWT_PRED2 = 16'sd14466;
    localparam logic signed [15:0] LWT_UPD2  = 16'sd7266;
    localparam logic signed [15:0] LWT_GAIN  = 16'sd18835;
    localparam logic signed [15:0] LWT_IGAIN = 16'sd14252;
endpackage

// File: rtl/lwt_mulrnd.sv
`timescale 1ns/1ps
// Signed fixed-point multiply with round-half-up and truncation.
// Assumes: coef has FRAC fraction bits; the result fits in OW bits.
module lwt_mulrnd #(
    parameter int IW   = 15,
    parameter int CW   = 16,
    parameter int OW   = 14,
    parameter int FRAC = 14
) (
    input  logic signed [IW-1:0] val,
    input  logic signed [CW-1:0] coef,
    output logic signed [OW-1:0] res
);
    localparam int PW = IW + CW;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    // Full-width product, rounding bias, arithmetic shift down.
    always_comb begin
        prod   = val * coef;
        biased = prod + HALF;
        res    = OW'(biased >>> FRAC);
    end
endmodule

// File: rtl/lwt_split.sv
`timescale 1ns/1ps
// Splits the sample stream into even/odd pairs and flags odd-length lines.
// Assumes: at most one sample per clock; in_sol restarts the even phase.
module lwt_split #(
    parameter int DW = 10,
    parameter int W  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_sample,
    input  logic                in_sol,
    input  logic                in_eol,
    output logic                pair_valid,
    output logic signed [W-1:0] pair_even,
    output logic signed [W-1:0] pair_odd,
    output logic                pair_first,
    output logic                pair_last,
    output logic                odd_err
);
    localparam int EXT = W - DW;

    logic                phase_odd;
    logic                take_even;
    logic signed [W-1:0] ext;
    logic signed [W-1:0] ev_hold;
    logic                first_hold;

    // Sign extension and phase decision for the incoming sample.
    always_comb begin
        ext       = {{EXT{in_sample[DW-1]}}, in_sample};
        take_even = in_sol || !phase_odd;
    end

    // Phase tracking, pair strobe and odd-length pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_odd  <= 1'b0;
            pair_valid <= 1'b0;
            odd_err    <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            odd_err    <= 1'b0;
            if (in_valid) begin
                if (take_even) begin
                    phase_odd <= !in_eol;
                    odd_err   <= in_eol;
                end else begin
                    pair_valid <= 1'b1;
                    phase_odd  <= 1'b0;
                end
            end
        end
    end

    // Even sample holding and pair assembly.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            if (take_even) begin
                ev_hold    <= ext;
                first_hold <= in_sol;
            end else begin
                pair_even  <= ev_hold;
                pair_odd   <= ext;
                pair_first <= first_hold;
                pair_last  <= in_eol;
            end
        end
    end
endmodule

// File: rtl/lwt_predict.sv
`timescale 1ns/1ps
// Predict step: b(n) += COEF * (a(n) + a(n+1)). Holds one pair until its
// right neighbour arrives; at a line end it mirrors a(n+1) = a(n).
// Assumes: pairs arrive at most every other cycle except a line's tail.
module lwt_predict #(
    parameter int W    = 14,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter logic signed [CW-1:0] COEF = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_b,
    input  logic                in_first,
    input  logic                in_last,
    output logic                out_valid,
    output logic signed [W-1:0] out_a,
    output logic signed [W-1:0] out_b,
    output logic                out_first,
    output logic                out_last
);
    logic                held_v;
    logic signed [W-1:0] ha, hb;
    logic                hf, hl;
    logic                flush, step;
    logic signed [W-1:0] nbr;
    logic signed [W:0]   nsum;
    logic signed [W-1:0] corr;

    // Emit decision and neighbour selection with end-of-line mirror.
    always_comb begin
        flush = held_v && (hl || (in_valid && in_first));
        step  = held_v && !flush && in_valid;
        nbr   = flush ? ha : in_a;
        nsum  = {ha[W-1], ha} + {nbr[W-1], nbr};
    end

    lwt_mulrnd #(.IW(W + 1), .CW(CW), .OW(W), .FRAC(FRAC)) u_mul (
        .val  (nsum),
        .coef (COEF),
        .res  (corr)
    );

    // Control: occupancy of the holding slot and output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= flush || step;
            if (in_valid) begin
                held_v <= 1'b1;
            end else if (flush) begin
                held_v <= 1'b0;
            end
        end
    end

    // Data: capture incoming pair, produce the predicted pair.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            ha <= in_a;
            hb <= in_b;
            hf <= in_first;
            hl <= in_last;
        end
        if (flush || step) begin
            out_a     <= ha;
            out_b     <= hb + corr;
            out_first <= hf;
            out_last  <= flush;
        end
    end
endmodule

// File: rtl/lwt_update.sv
`timescale 1ns/1ps
// Update step: a(n) += COEF * (b(n-1) + b(n)), mirroring b(-1) = b(0)
// on the first pair of a line. One register stage, no stalls.
module lwt_update #(
    parameter int W    = 14,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter logic signed [CW-1:0] COEF = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_b,
    input  logic                in_first,
    input  logic                in_last,
    output logic                out_valid,
    output logic signed [W-1:0] out_a,
    output logic signed [W-1:0] out_b,
    output logic                out_first,
    output logic                out_last
);
    logic signed [W-1:0] prev_b;
    logic signed [W-1:0] left;
    logic signed [W:0]   usum;
    logic signed [W-1:0] corr;

    // Left neighbour with start-of-line mirror.
    always_comb begin
        left = in_first ? in_b : prev_b;
        usum = {left[W-1], left} + {in_b[W-1], in_b};
    end

    lwt_mulrnd #(.IW(W + 1), .CW(CW), .OW(W), .FRAC(FRAC)) u_mul (
        .val  (usum),
        .coef (COEF),
        .res  (corr)
    );

    // Output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Updated pair and remembered detail value.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_a     <= in_a + corr;
            out_b     <= in_b;
            out_first <= in_first;
            out_last  <= in_last;
            prev_b    <= in_b;
        end
    end
endmodule

// File: rtl/lwt_core.sv
`timescale 1ns/1ps
// Forward lifting wavelet filter: split, two predict/update pairs, gains.
// Assumes: one sample per clock at most; lines framed by in_sol/in_eol.
module lwt_core
    import lwt_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int GUARD  = 4,
    parameter int COEF_W = LWT_COEF_W,
    parameter int FRAC   = LWT_FRAC,
    parameter logic signed [COEF_W-1:0] PRED1 = COEF_W'(LWT_PRED1),
    parameter logic signed [COEF_W-1:0] UPD1  = COEF_W'(LWT_UPD1),
    parameter logic signed [COEF_W-1:0] PRED2 = COEF_W'(LWT_PRED2),
    parameter logic signed [COEF_W-1:0] UPD2  = COEF_W'(LWT_UPD2),
    parameter logic signed [COEF_W-1:0] GAIN  = COEF_W'(LWT_GAIN),
    parameter logic signed [COEF_W-1:0] IGAIN = COEF_W'(LWT_IGAIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_sample,
    input  logic                      in_sol,
    input  logic                      in_eol,
    output logic                      out_valid,
    output logic [DATA_W+GUARD-1:0]   out_low,
    output logic [DATA_W+GUARD-1:0]   out_high,
    output logic                      out_sol,
    output logic                      out_eol,
    output logic                      err_odd
);
    localparam int W    = DATA_W + GUARD;
    localparam int NSTG = LWT_STAGES;
    localparam logic signed [COEF_W-1:0] PRED_TAB [NSTG] = '{PRED1, PRED2};
    localparam logic signed [COEF_W-1:0] UPD_TAB  [NSTG] = '{UPD1, UPD2};

    logic                cv [NSTG+1];
    logic signed [W-1:0] ca [NSTG+1];
    logic signed [W-1:0] cb [NSTG+1];
    logic                cf [NSTG+1];
    logic                cl [NSTG+1];
    logic                pv [NSTG];
    logic signed [W-1:0] pa [NSTG];
    logic signed [W-1:0] pb [NSTG];
    logic                pf [NSTG];
    logic                pl [NSTG];
    logic signed [W-1:0] lo_s, hi_s;

    lwt_split #(.DW(DATA_W), .W(W)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_sol     (in_sol),
        .in_eol     (in_eol),
        .pair_valid (cv[0]),
        .pair_even  (ca[0]),
        .pair_odd   (cb[0]),
        .pair_first (cf[0]),
        .pair_last  (cl[0]),
        .odd_err    (err_odd)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_lift
        lwt_predict #(.W(W), .CW(COEF_W), .FRAC(FRAC), .COEF(PRED_TAB[g])) u_pred (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (cv[g]),
            .in_a      (ca[g]),
            .in_b      (cb[g]),
            .in_first  (cf[g]),
            .in_last   (cl[g]),
            .out_valid (pv[g]),
            .out_a     (pa[g]),
            .out_b     (pb[g]),
            .out_first (pf[g]),
            .out_last  (pl[g])
        );
        lwt_update #(.W(W), .CW(COEF_W), .FRAC(FRAC), .COEF(UPD_TAB[g])) u_upd (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (pv[g]),
            .in_a      (pa[g]),
            .in_b      (pb[g]),
            .in_first  (pf[g]),
            .in_last   (pl[g]),
            .out_valid (cv[g+1]),
            .out_a     (ca[g+1]),
            .out_b     (cb[g+1]),
            .out_first (cf[g+1]),
            .out_last  (cl[g+1])
        );
    end

    lwt_mulrnd #(.IW(W), .CW(COEF_W), .OW(W), .FRAC(FRAC)) u_lo_gain (
        .val  (ca[NSTG]),
        .coef (IGAIN),
        .res  (lo_s)
    );
    lwt_mulrnd #(.IW(W), .CW(COEF_W), .OW(W), .FRAC(FRAC)) u_hi_gain (
        .val  (cb[NSTG]),
        .coef (GAIN),
        .res  (hi_s)
    );

    // Output register for the scaled coefficient pair and line markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
            out_low   <= '0;
            out_high  <= '0;
        end else begin
            out_valid <= cv[NSTG];
            if (cv[NSTG]) begin
                out_low  <= lo_s;
                out_high <= hi_s;
                out_sol  <= cf[NSTG];
                out_eol  <= cl[NSTG];
            end
        end
    end
endmodule

// File: rtl/lwt_checker.sv
`timescale 1ns/1ps
// Protocol checks on the filter's ports; attached to lwt_core by bind.
// Assumes well-framed lines of at least two pairs, one sample per clock.
module lwt_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_eol,
    input logic out_valid,
    input logic out_sol,
    input logic out_eol,
    input logic err_odd
);
    logic [31:0] n_in, n_out;
    logic        seen, last_eol;

    // Running counts of samples in and pairs out, last end marker seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_in     <= '0;
            n_out    <= '0;
            seen     <= 1'b0;
            last_eol <= 1'b0;
        end else begin
            if (in_valid) n_in <= n_in + 32'd1;
            if (out_valid) begin
                n_out    <= n_out + 32'd1;
                seen     <= 1'b1;
                last_eol <= out_eol;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !err_odd));

    a_r9_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (n_in >= (n_out << 1) + 32'd2));

    a_r9_markers_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (out_sol == last_eol));

    a_r10_err_follows_eol: assert property (@(posedge clk) disable iff (!rst_n)
        err_odd |-> $past(in_valid && in_eol));
endmodule

bind lwt_core lwt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eol    (in_eol),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .err_odd   (err_odd)
);

// File: tb/sim_lwt_core.sv
`timescale 1ns/1ps
// Self-checking bench: directed edge lines plus a sweep of random lines,
// expected coefficients computed from the integer lifting formulas.
module sim_lwt_core;
    localparam int DW = 10;
    localparam int W  = 14;
    localparam longint CA = -25987, CB = -868, CC = 14466, CD = 7266;
    localparam longint KG = 18835, KI = 14252;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic out_valid, out_sol, out_eol, err_odd;
    logic [W-1:0] out_low, out_high;

    int checks = 0, fails = 0;
    bit err_pending = 1'b0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    longint q_lo[$], q_hi[$];
    bit     q_sol[$], q_eol[$];
    string  q_tag[$];

    always #10 clk = ~clk;

    lwt_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid),
        .out_low(out_low), .out_high(out_high), .out_sol(out_sol),
        .out_eol(out_eol), .err_odd(err_odd)
    );

    function automatic longint rq(longint p);
        return (p + 64'sd8192) >>> 14;
    endfunction

    function automatic logic [31:0] rnd32();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic note(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected pairs of an even-length line (R3..R8).
    task automatic push_model(int len, longint x[], string tag);
        int n = len / 2;
        longint d1[], s1[], d2[], s2[];
        d1 = new[n]; s1 = new[n]; d2 = new[n]; s2 = new[n];
        for (int k = 0; k < n; k++)
            d1[k] = x[2*k+1] + rq(CA * (x[2*k] + ((k == n-1) ? x[2*k] : x[2*k+2])));
        for (int k = 0; k < n; k++)
            s1[k] = x[2*k] + rq(CB * (((k == 0) ? d1[0] : d1[k-1]) + d1[k]));
        for (int k = 0; k < n; k++)
            d2[k] = d1[k] + rq(CC * (s1[k] + ((k == n-1) ? s1[k] : s1[k+1])));
        for (int k = 0; k < n; k++)
            s2[k] = s1[k] + rq(CD * (((k == 0) ? d2[0] : d2[k-1]) + d2[k]));
        for (int k = 0; k < n; k++) begin
            q_lo.push_back(rq(KI * s2[k]));
            q_hi.push_back(rq(KG * d2[k]));
            q_sol.push_back(k == 0);
            q_eol.push_back(k == n-1);
            q_tag.push_back(tag);
        end
    endtask

    // One cycle; the odd-length pulse is checked every cycle (R10).
    task automatic tick_check();
        @(posedge clk);
        #5;
        note(err_odd == err_pending, "R10", "err_odd", longint'(err_odd), longint'(err_pending));
    endtask

    task automatic idle(int n);
        repeat (n) begin
            tick_check();
            in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
            err_pending = 1'b0;
        end
    endtask

    task automatic send_line(int len, int pat, string tag, int maxgap);
        longint x[];
        x = new[len];
        for (int i = 0; i < len; i++) begin
            case (pat)
                0: x[i] = i * 37 - 100;
                1: x[i] = 100;
                2: x[i] = (i == 0) ? 300 : 0;
                3: x[i] = (i == len-1) ? 300 : 0;
                4: x[i] = (i % 2 == 0) ? 511 : -512;
                default: x[i] = longint'(rnd32() % 1024) - 512;
            endcase
        end
        push_model(len - (len % 2), x, tag);
        for (int i = 0; i < len; i++) begin
            tick_check();
            in_valid = 1'b1;
            in_sample = DW'(x[i]);
            in_sol = (i == 0);
            in_eol = (i == len-1);
            err_pending = (i == len-1) && (len % 2 == 1);
            if (maxgap > 0) idle(int'(rnd32() % (maxgap + 1)));
        end
    endtask

    // Output monitor, sampled away from the active edge (R3..R9).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_lo.size() == 0) begin
                note(1'b0, "R9", "unexpected output pair", 1, 0);
            end else begin
                longint elo, ehi, alo, ahi;
                bit es, ee;
                string tg;
                elo = q_lo.pop_front(); ehi = q_hi.pop_front();
                es = q_sol.pop_front(); ee = q_eol.pop_front(); tg = q_tag.pop_front();
                alo = longint'($signed(out_low));
                ahi = longint'($signed(out_high));
                checks++;
                if (alo != elo || ahi != ehi || out_sol != es || out_eol != ee) begin
                    fails++;
                    $display("FAIL %s: low %0d exp %0d, high %0d exp %0d, sol %0d exp %0d, eol %0d exp %0d",
                             tg, alo, elo, ahi, ehi, out_sol, es, out_eol, ee);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        note(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        idle(3);
        note(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        send_line(4, 0, "R3", 0);
        send_line(8, 1, "R5", 0);
        send_line(6, 2, "R7", 0);
        send_line(6, 3, "R8", 0);
        send_line(10, 4, "R6", 0);
        send_line(12, 5, "R4", 0);
        send_line(16, 5, "R11", 2);
        send_line(7, 5, "R10", 0);
        send_line(8, 0, "R10", 1);
        for (int k = 0; k < 40; k++)
            send_line(4 + 2 * int'(rnd32() % 10), 5, "R2", k % 2);
        idle(80);
        note(q_lo.size() == 0, "R9", "pairs still owed", longint'(q_lo.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: finished 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule